// File: doc/BRIEF.md
# Dual Receive Buffer with Destination Filter

This block sits between a byte-wide receive stream and a pair of frame buffers in a memory-mapped address space. Each incoming frame is presented one byte per cycle with a valid strobe and a last marker. While the frame arrives, its bytes are written straight into the active buffer through a write port. The first six bytes are compared against a 48-bit station address along the way. When the last byte arrives the block decides whether the frame is kept. A kept frame marks its buffer full, may pulse an interrupt, and in alternating mode moves reception over to the other buffer.

Software owns a buffer from the moment it is marked full. It reads the frame, then writes zero to the full flag to hand the buffer back. The block holds a ready indication low while the active buffer is full. Any frame that starts while the active buffer is full is dropped without a single write. Frames that fail the filter or run too long are discarded and leave the full flags and the buffer selection untouched.

Top module: `rxpp_top`

## Requirements
- R1: A frame whose first byte has bit 7 set is kept, whatever its length (one byte or more), provided it is not dropped or too long.
- R2: A frame whose first byte has bit 7 clear is kept only if it has at least six bytes and byte k (k = 0..5) equals `station_addr[47-8k -: 8]`; otherwise it is discarded with no full flag set, no interrupt and no change of the active buffer.
- R3: A frame whose first byte arrives while the active buffer's full flag is set is dropped: `buf_we` stays low for all of its bytes and no flag, interrupt or selection changes.
- R4: A frame of MAX_FRAME (default 2020) bytes or more is rejected as in R2; a frame of MAX_FRAME-1 bytes is kept. Bytes at offset MAX_FRAME-1 and beyond are never written.
- R5: When a frame is kept, bit 0 of its buffer's control word is set; `irq` is high for exactly the one cycle after the clock edge that samples the last byte if bit 3 of that control word and bit 31 of the global word are both 1, and stays low otherwise.
- R6: With PINGPONG = 1 the active buffer alternates 0, 1, 0, ... on each kept frame; with PINGPONG = 0 it stays at buffer 0.
- R7: After reset the active buffer is 0, all control and global words read 0, `irq` is low and `rx_ready` is high.
- R8: `rx_ready` is high exactly when bit 0 of the active buffer's control word is 0; a software write of 0 to that bit frees the buffer.
- R9: Byte k of a frame that is not dropped appears on the write port in the cycle it is presented, at byte address 0x1000 + 0x800*b + k, where b is the active buffer.
- R10: Register words: control of buffer 0 at 0x17FC, control of buffer 1 at 0x1FFC, global word at 0x07F8; each stores the full written word, is read back combinationally on `reg_rdata`, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte on `rx_data` is valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Current byte ends the frame |
| station_addr | input | 48 | Station address, first byte in bits 47:40 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| buf_we | output | 1 | Buffer byte write enable |
| buf_addr | output | 13 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| rx_ready | output | 1 | Active buffer is free |
| irq | output | 1 | One-cycle frame-kept interrupt |

## Verification
A wrong filter or length flag shows up one cycle after the last byte, as a full flag set or left clear in the control word and as an interrupt pulse that appears or goes missing. A wrong active-buffer selection shows in the next frame, whose writes land in the other half of the buffer space, and in `rx_ready` tracking the wrong flag at once. A wrong drop decision shows during the frame itself as write strobes on a full buffer.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int          REG_AW     = 13;
  localparam int          DATA_W     = 32;
  localparam logic [12:0] BUF_BASE   = 13'h1000;
  localparam logic [12:0] BUF_STRIDE = 13'h0800;
  localparam logic [12:0] CTRL_OFS   = 13'h07FC;
  localparam logic [12:0] GLOBAL_ADR = 13'h07F8;
  localparam int          FULL_BIT   = 0;
  localparam int          IE_BIT     = 3;
  localparam int          GIE_BIT    = 31;
  localparam int          NUM_BUF    = 2;
  localparam int          ADDR_BYTES = 6;
endpackage

// File: rtl/rxpp_addr_filter.sv
module rxpp_addr_filter
  import rxpp_pkg::*;
#(
  parameter int IDXW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_en,
  input  logic            first,
  input  logic [IDXW-1:0] idx,
  input  logic [7:0]      data,
  input  logic [47:0]     station_addr,
  output logic            pass_now
);
  logic        grp_q, grp_n;
  logic        match_q, match_n;
  logic [47:0] shifted;
  logic [7:0]  cmp_byte;
  logic        in_addr;

  always_comb begin
    shifted  = station_addr << {idx[2:0], 3'b000};
    cmp_byte = shifted[47:40];
    in_addr  = (idx < IDXW'(ADDR_BYTES));
    grp_n    = first ? data[7] : grp_q;
    match_n  = (first ? 1'b1 : match_q) & (in_addr ? (data == cmp_byte) : 1'b1);
    pass_now = grp_n | (match_n & (idx >= IDXW'(ADDR_BYTES - 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q   <= 1'b0;
      match_q <= 1'b0;
    end else if (byte_en) begin
      grp_q   <= grp_n;
      match_q <= match_n;
    end
  end
endmodule

// File: rtl/rxpp_frame_track.sv
module rxpp_frame_track #(
  parameter int MAX_FRAME = 2020,
  parameter int IDXW      = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic            rx_last,
  input  logic            full_now,
  output logic            first,
  output logic [IDXW-1:0] idx,
  output logic            drop_now,
  output logic            ovf_now,
  output logic            wr_en
);
  localparam logic [IDXW-1:0] LIMIT = IDXW'(MAX_FRAME - 1);

  logic            mid_q, mid_n;
  logic [IDXW-1:0] idx_q, idx_n;
  logic            drop_q, drop_n;
  logic            ovf_q, ovf_n;

  always_comb begin
    first    = !mid_q;
    idx      = mid_q ? idx_q : '0;
    drop_now = first ? full_now : drop_q;
    ovf_now  = (first ? 1'b0 : ovf_q) | (idx >= LIMIT);
    wr_en    = rx_valid & !drop_now & !ovf_now;

    mid_n  = mid_q;
    idx_n  = idx_q;
    drop_n = drop_q;
    ovf_n  = ovf_q;
    if (rx_valid) begin
      mid_n  = !rx_last;
      idx_n  = rx_last ? '0 : ((idx >= LIMIT) ? LIMIT : idx + 1'b1);
      drop_n = drop_now;
      ovf_n  = ovf_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= 1'b0;
      idx_q  <= '0;
      drop_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      mid_q  <= mid_n;
      idx_q  <= idx_n;
      drop_q <= drop_n;
      ovf_q  <= ovf_n;
    end
  end
endmodule

// File: rtl/rxpp_regs.sv
module rxpp_regs
  import rxpp_pkg::*;
#(
  parameter int PINGPONG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              accept,
  output logic              act,
  output logic              full_act,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q [NUM_BUF];
  logic [DATA_W-1:0] ctrl_n [NUM_BUF];
  logic [NUM_BUF-1:0] hit;
  logic [DATA_W-1:0] gie_q, gie_n;
  logic               act_q, act_n;
  logic               irq_q, irq_n;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    localparam logic [REG_AW-1:0] CADR = BUF_BASE + REG_AW'(b) * BUF_STRIDE + CTRL_OFS;
    always_comb begin
      hit[b]    = (reg_addr == CADR);
      ctrl_n[b] = (reg_we && hit[b]) ? reg_wdata : ctrl_q[b];
      if (accept && (act_q == b[0]))
        ctrl_n[b][FULL_BIT] = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[b] <= '0;
      else        ctrl_q[b] <= ctrl_n[b];
    end
  end

  always_comb begin
    gie_n = (reg_we && reg_addr == GLOBAL_ADR) ? reg_wdata : gie_q;
    act_n = (accept && PINGPONG != 0) ? !act_q : act_q;
    irq_n = accept & ctrl_q[act_q][IE_BIT] & gie_q[GIE_BIT];
    if (hit[0])                        reg_rdata = ctrl_q[0];
    else if (hit[1])                   reg_rdata = ctrl_q[1];
    else if (reg_addr == GLOBAL_ADR)   reg_rdata = gie_q;
    else                               reg_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= '0;
      act_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      gie_q <= gie_n;
      act_q <= act_n;
      irq_q <= irq_n;
    end
  end

  assign act      = act_q;
  assign full_act = ctrl_q[act_q][FULL_BIT];
  assign irq      = irq_q;

  // R5: an interrupt only follows a frame that marked the previous buffer full
  a_r5_irq_marks_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[$past(act_q)][FULL_BIT]);

  if (PINGPONG != 0) begin : g_pp
    // R6: each kept frame moves reception to the other buffer
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (act_q != $past(act_q)));
  end else begin : g_fixed
    // R6: fixed mode never leaves buffer 0
    a_r6_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !act_q);
  end
endmodule

// File: rtl/rxpp_top.sv
module rxpp_top
  import rxpp_pkg::*;
#(
  parameter int MAX_FRAME = 2020,
  parameter int PINGPONG  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic [47:0] station_addr,
  input  logic        reg_we,
  input  logic [12:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        buf_we,
  output logic [12:0] buf_addr,
  output logic [7:0]  buf_wdata,
  output logic        rx_ready,
  output logic        irq
);
  localparam int IDXW = $clog2(MAX_FRAME + 1);

  logic            rst_s1_n, rst_s2_n;
  logic            trk_first, trk_drop, trk_ovf, trk_wr;
  logic [IDXW-1:0] trk_idx;
  logic            flt_pass;
  logic            accept;
  logic            act, full_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_s2_n <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_s2_n <= rst_s1_n;
    end
  end

  rxpp_frame_track #(.MAX_FRAME(MAX_FRAME), .IDXW(IDXW)) u_track (
    .clk      (clk),
    .rst_n    (rst_s2_n),
    .rx_valid (rx_valid),
    .rx_last  (rx_last),
    .full_now (full_act),
    .first    (trk_first),
    .idx      (trk_idx),
    .drop_now (trk_drop),
    .ovf_now  (trk_ovf),
    .wr_en    (trk_wr)
  );

  rxpp_addr_filter #(.IDXW(IDXW)) u_filter (
    .clk          (clk),
    .rst_n        (rst_s2_n),
    .byte_en      (rx_valid & !trk_drop),
    .first        (trk_first),
    .idx          (trk_idx),
    .data         (rx_data),
    .station_addr (station_addr),
    .pass_now     (flt_pass)
  );

  assign accept = rx_valid & rx_last & !trk_drop & !trk_ovf & flt_pass;

  rxpp_regs #(.PINGPONG(PINGPONG)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s2_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .accept    (accept),
    .act       (act),
    .full_act  (full_act),
    .irq       (irq)
  );

  assign buf_we    = trk_wr;
  assign buf_addr  = BUF_BASE + (act ? BUF_STRIDE : 13'h0) + 13'(trk_idx);
  assign buf_wdata = rx_data;
  assign rx_ready  = !full_act;

  // R3: a frame starting on a full buffer never reaches the write port
  a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_s2_n)
    (rx_valid && trk_first && !rx_ready) |-> !buf_we);

  // R4: writes stay below the length limit inside the buffer window
  a_r4_write_in_window: assert property (@(posedge clk) disable iff (!rst_s2_n)
    buf_we |-> ((buf_addr & 13'h07FF) < 13'(MAX_FRAME - 1)));

  // R2: a kept frame with bit 7 clear has reached the sixth byte
  a_r2_unicast_long_enough: assert property (@(posedge clk) disable iff (!rst_s2_n)
    (accept && trk_first && !rx_data[7]) |-> 1'b0 == accept);
endmodule

// File: tb/rxpp_top_test.sv
module rxpp_top_test;
  localparam logic [47:0] STA = 48'h021A2B3C4D5E;
  localparam int          MAXF = 2020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        reg_we = 1'b0;
  logic [12:0] reg_addr = 13'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        buf_we, rx_ready, irq;
  logic [12:0] buf_addr;
  logic [7:0]  buf_wdata;

  logic        f_we = 1'b0;
  logic [12:0] f_addr = 13'h0;
  logic [31:0] f_wdata = 32'h0;
  logic [31:0] f_rdata;
  logic        f_buf_we, f_ready, f_irq;
  logic [12:0] f_buf_addr;
  logic [7:0]  f_buf_wdata;

  int tests = 0, fails = 0;
  int irq_cnt = 0, wr_cnt = 0, f_wr1 = 0;
  int cyc = 0, last_cyc = 0, irq_cyc = 0;
  logic [7:0] mem [0:4095];

  always #4 clk = ~clk;

  rxpp_top #(.MAX_FRAME(MAXF), .PINGPONG(1)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .station_addr(STA), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .rx_ready(rx_ready), .irq(irq));

  rxpp_top #(.MAX_FRAME(MAXF), .PINGPONG(0)) uut_fixed (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .station_addr(STA), .reg_we(f_we), .reg_addr(f_addr),
    .reg_wdata(f_wdata), .reg_rdata(f_rdata), .buf_we(f_buf_we),
    .buf_addr(f_buf_addr), .buf_wdata(f_buf_wdata), .rx_ready(f_ready), .irq(f_irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (irq) begin irq_cnt <= irq_cnt + 1; irq_cyc <= cyc; end
    if (rx_valid && rx_last) last_cyc <= cyc;
    if (buf_we) begin
      wr_cnt <= wr_cnt + 1;
      mem[buf_addr - 13'h1000] <= buf_wdata;
    end
    if (f_buf_we && f_buf_addr >= 13'h1800) f_wr1 <= f_wr1 + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int mode, input int k, input int seed);
    logic [47:0] s;
    s = STA << (8 * (k % 8));
    if (mode == 1 && k == 0) return 8'h81 ^ 8'(seed);
    if (mode != 1 && k < 6) return (mode == 2 && k == 5) ? (s[47:40] ^ 8'h01) : s[47:40];
    return 8'((k * 7 + seed) & 8'hFF) | ((mode == 1 && k == 0) ? 8'h80 : 8'h00);
  endfunction

  task automatic send(input int mode, input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbyte(mode, k, seed);
      rx_last  = (k == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fwr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    f_we = 1'b1; f_addr = a; f_wdata = d;
    @(negedge clk);
    f_we = 1'b0;
  endtask

  // {mode[1:0], len[11:0], keep}; mode 0 station, 1 bit 7 set, 2 near-miss
  localparam logic [14:0] VEC [8] = '{
    {2'd0, 12'd64,  1'b1}, {2'd1, 12'd10, 1'b1}, {2'd2, 12'd64, 1'b0},
    {2'd1, 12'd1,   1'b1}, {2'd0, 12'd6,  1'b1}, {2'd0, 12'd5,  1'b0},
    {2'd2, 12'd3,   1'b0}, {2'd1, 12'd300, 1'b1}};

  logic [31:0] rv;
  logic        exp_act = 1'b0;

  initial begin : watchdog
    #1600000;
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 / R10 reset state
    rd(13'h17FC, rv); check("R7 ctrl0 reset", rv, 32'h0);
    rd(13'h1FFC, rv); check("R7 ctrl1 reset", rv, 32'h0);
    rd(13'h07F8, rv); check("R7 global reset", rv, 32'h0);
    check("R7 ready after reset", {31'h0, rx_ready}, 32'h1);
    check("R7 irq after reset", {31'h0, irq}, 32'h0);

    // R10 register storage and readback
    wr(13'h07F8, 32'h8000_0000);
    wr(13'h17FC, 32'h0000_0008);
    wr(13'h1FFC, 32'h0000_0008);
    rd(13'h07F8, rv); check("R10 global readback", rv, 32'h8000_0000);
    rd(13'h1FFC, rv); check("R10 ctrl1 readback", rv, 32'h8);
    rd(13'h0100, rv); check("R10 unmapped reads 0", rv, 32'h0);

    // Table walk: R1, R2, R5, R6, R9
    for (int v = 0; v < 8; v++) begin
      int mode, len;
      logic keep;
      logic [12:0] ca, oa;
      mode = int'(VEC[v][14:13]);
      len  = int'(VEC[v][12:1]);
      keep = VEC[v][0];
      ca = exp_act ? 13'h1FFC : 13'h17FC;
      oa = exp_act ? 13'h17FC : 13'h1FFC;
      irq_cnt = 0;
      send(mode, len, v);
      rd(ca, rv);
      check(keep ? "R1/R2 kept frame sets full" : "R2 discarded frame leaves flag", rv, keep ? 32'h9 : 32'h8);
      rd(oa, rv); check("R6 other buffer untouched", rv, 32'h8);
      check("R5 irq count", irq_cnt, keep ? 1 : 0);
      if (keep) begin
        check("R5 irq one cycle after last byte", irq_cyc - last_cyc, 1);
        check("R9 first byte stored", {24'h0, mem[(exp_act ? 12'h800 : 12'h0) + 12'h0]}, {24'h0, fbyte(mode, 0, v)});
        check("R9 last byte stored", {24'h0, mem[(exp_act ? 12'h800 : 12'h0) + 12'(len - 1)]}, {24'h0, fbyte(mode, len - 1, v)});
        wr(ca, 32'h8);
        exp_act = !exp_act;
      end
    end

    // R4: length limit
    irq_cnt = 0;
    send(1, MAXF, 40);
    rd(exp_act ? 13'h1FFC : 13'h17FC, rv); check("R4 oversize rejected", rv, 32'h8);
    check("R4 oversize no irq", irq_cnt, 0);
    irq_cnt = 0;
    send(1, MAXF - 1, 41);
    rd(exp_act ? 13'h1FFC : 13'h17FC, rv); check("R4 limit-1 kept", rv, 32'h9);
    check("R4 limit-1 irq", irq_cnt, 1);
    wr(exp_act ? 13'h1FFC : 13'h17FC, 32'h8);
    exp_act = !exp_act;

    // R3 / R8: both buffers full, then a frame is dropped
    send(1, 8, 50); exp_act = !exp_act;
    send(1, 8, 51); exp_act = !exp_act;
    check("R8 ready low when active full", {31'h0, rx_ready}, 32'h0);
    wr_cnt = 0; irq_cnt = 0;
    send(1, 8, 52);
    check("R3 dropped frame writes nothing", wr_cnt, 0);
    check("R3 dropped frame no irq", irq_cnt, 0);
    rd(exp_act ? 13'h1FFC : 13'h17FC, rv); check("R3 flag unchanged", rv, 32'h9);
    wr(exp_act ? 13'h1FFC : 13'h17FC, 32'h8);
    check("R8 ready after clear", {31'h0, rx_ready}, 32'h1);
    wr(exp_act ? 13'h17FC : 13'h1FFC, 32'h8);

    // R5: enables gate the interrupt but not the flag
    wr(13'h07F8, 32'h0);
    irq_cnt = 0;
    send(0, 20, 60);
    check("R5 global off no irq", irq_cnt, 0);
    rd(exp_act ? 13'h1FFC : 13'h17FC, rv); check("R5 flag set with global off", rv, 32'h9);
    wr(exp_act ? 13'h1FFC : 13'h17FC, 32'h8);
    exp_act = !exp_act;
    wr(13'h07F8, 32'h8000_0000);
    wr(exp_act ? 13'h1FFC : 13'h17FC, 32'h0);
    irq_cnt = 0;
    send(0, 20, 61);
    check("R5 buffer enable off no irq", irq_cnt, 0);
    rd(exp_act ? 13'h1FFC : 13'h17FC, rv); check("R5 flag set with enable off", rv, 32'h1);

    // R6: fixed mode stays on buffer 0
    fwr(13'h17FC, 32'h0);
    fwr(13'h1FFC, 32'h0);
    f_wr1 = 0;
    send(0, 12, 70);
    @(negedge clk); f_addr = 13'h17FC; #1 check("R6 fixed first frame in buffer 0", f_rdata, 32'h1);
    fwr(13'h17FC, 32'h0);
    send(1, 12, 71);
    @(negedge clk); f_addr = 13'h17FC; #1 check("R6 fixed second frame in buffer 0", f_rdata, 32'h1);
    @(negedge clk); f_addr = 13'h1FFC; #1 check("R6 fixed buffer 1 unused", f_rdata, 32'h0);
    check("R6 fixed no writes to buffer 1", f_wr1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule